// File: doc/BRIEF.md
# Triggered Acquisition Cycle Controller

This block decides which words of an incoming sample stream are written to a capture buffer. Software arms it with a start strobe. Each acquisition cycle then waits for a trigger, writes a programmed number of words, and returns to waiting. After a programmed number of cycles the unit stops on its own and raises a done flag.

The trigger can come from four places: the unit can run freely, wait for a software strobe, watch a hardware digital line, or wait for a pulse from an analog comparator. The digital line can be qualified by either level or either edge. A keep-one-in-n prescaler thins the stream inside each cycle. Pause and resume strobes freeze and continue acquisition, and a flush strobe clears a running count of written words.

The block is used between a sampling front end and a buffer writer. The external trigger line is assumed to be already synchronous to the clock.

Top module: `acq_cycle_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en` and `word_cnt` are all zero.
- R2: With `cfg_mode` = 0 (free-running), a cycle begins without any trigger. The cycle begins one clock after the unit becomes armed, and the unit becomes armed one clock after `start_i`.
- R3: With `cfg_mode` = 1, a cycle begins on `sw_trig_i`, but only while the unit is armed. A strobe given while the unit is stopped has no effect.
- R4: With `cfg_mode` = 2, `hw_dig_i` is qualified by `cfg_dig_beh`: 1 is a high level, 2 is a low level, 3 is a 0-to-1 transition and 4 is a 1-to-0 transition. Any other code never triggers.
- R5: With `cfg_mode` = 3, a cycle begins on a pulse of `hw_ana_i`.
- R6: Each cycle writes exactly `cfg_words` kept words, with 0 treated as 1. A trigger that arrives while a cycle is writing is ignored. A new cycle can start only after the current one ends, including in the level modes.
- R7: When the number of completed cycles reaches a nonzero `cfg_cycles`, the unit stops by itself: `busy` falls and `done` rises. `done` stays high until the next start. A `cfg_cycles` of 0 means the unit never stops by itself.
- R8: Within a cycle, the first valid word is kept and then every n-th valid word after it, where n = `cfg_presc`. The values 0 and 1 keep every word. The phase restarts at each trigger.
- R9: A pause stops both trigger detection and writing, and freezes the word position inside the cycle. Triggers that arrive while paused are discarded. A resume returns the unit to the state it left and continues the cycle from where it stopped.
- R10: `word_cnt` rises by one for every written word. `flush_i` clears it, and a flush wins over a write in the same clock.
- R11: `stop_i` returns the unit to stopped from any state and wins over every other strobe. A pause blocks a trigger or a write in the same clock. A start given while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample word present |
| s_data | input | DATA_W | Sample word |
| start_i | input | 1 | Arm the unit and begin a new run |
| stop_i | input | 1 | Return to stopped |
| pause_i | input | 1 | Freeze acquisition |
| resume_i | input | 1 | Continue after a pause |
| flush_i | input | 1 | Clear the word counter |
| sw_trig_i | input | 1 | Software trigger strobe |
| hw_dig_i | input | 1 | Hardware digital trigger line |
| hw_ana_i | input | 1 | Analog comparator trigger pulse |
| cfg_mode | input | 2 | Trigger source: 0 free-running, 1 software, 2 digital, 3 analog |
| cfg_dig_beh | input | 3 | Digital trigger qualification code |
| cfg_cycles | input | CYC_W | Cycles per run, 0 for unlimited |
| cfg_words | input | WORDS_W | Words per cycle |
| cfg_presc | input | PRESC_W | Keep one word in this many |
| wr_en | output | 1 | Buffer write strobe |
| wr_data | output | DATA_W | Word to write |
| word_cnt | output | CNT_W | Words written since the last flush |
| busy | output | 1 | Unit is armed, capturing or paused |
| done | output | 1 | Last run ended by reaching its cycle limit |

## Verification
The bench covers several corner cases, each paired with the failure it would expose:
- Edge qualification is driven with the line held steady before arming. A design that treated a level as an edge, or that started with the wrong previous value, would trigger at once.
- A pause lands in the middle of a cycle and a software strobe is given while paused. Losing the in-cycle position would overshoot the word count, and taking the strobe would start a spurious cycle.
- A flush is given in the same clock as a write. This catches a counter that lets the write win.
- A prescaled run spans two cycles. A phase that is not restarted at the trigger would shift which words are kept.
- A long stretch of random strobes, triggers and configuration changes is compared clock by clock against a reference model written in the bench. This exposes errors in strobe priority and in the cycle limit.

// File: rtl/acq_pkg.sv
package acq_pkg;
   typedef enum logic [1:0] {
      TM_FREE    = 2'd0,
      TM_SOFT    = 2'd1,
      TM_DIGITAL = 2'd2,
      TM_ANALOG  = 2'd3
   } trig_mode_e;

   localparam logic [2:0] DB_LEVEL_HI = 3'd1;
   localparam logic [2:0] DB_LEVEL_LO = 3'd2;
   localparam logic [2:0] DB_EDGE_UP  = 3'd3;
   localparam logic [2:0] DB_EDGE_DN  = 3'd4;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_CAPT   = 2'd2,
      ST_PAUSED = 2'd3
   } acq_state_e;
endpackage

// File: rtl/acq_trig_qual.sv
module acq_trig_qual
   import acq_pkg::*;
#(
   parameter bit DIG_EDGE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic [2:0] dig_beh,
   input  logic       armed,
   input  logic       sw_trig,
   input  logic       dig_line,
   input  logic       ana_pulse,
   output logic       fire
);
   logic dig_hit;
   logic src_hit;

   generate
      if (DIG_EDGE_EN) begin : g_edges
         logic dig_prev;
         always_ff @(posedge clk) begin
            if (!rst_n) dig_prev <= 1'b0;
            else        dig_prev <= dig_line;
         end
         always_comb begin
            unique case (dig_beh)
               DB_LEVEL_HI: dig_hit = dig_line;
               DB_LEVEL_LO: dig_hit = !dig_line;
               DB_EDGE_UP:  dig_hit = dig_line && !dig_prev;
               DB_EDGE_DN:  dig_hit = !dig_line && dig_prev;
               default:     dig_hit = 1'b0;
            endcase
         end
      end else begin : g_levels
         always_comb begin
            unique case (dig_beh)
               DB_LEVEL_HI: dig_hit = dig_line;
               DB_LEVEL_LO: dig_hit = !dig_line;
               default:     dig_hit = 1'b0;
            endcase
         end
      end
   endgenerate

   always_comb begin
      unique case (trig_mode_e'(mode))
         TM_FREE:    src_hit = 1'b1;
         TM_SOFT:    src_hit = sw_trig;
         TM_DIGITAL: src_hit = dig_hit;
         TM_ANALOG:  src_hit = ana_pulse;
         default:    src_hit = 1'b0;
      endcase
   end

   assign fire = armed && src_hit;

   // R4: unknown behaviour codes never qualify the digital line
   a_r4_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_DIGITAL && (dig_beh == 3'd0 || dig_beh > DB_EDGE_DN)) |-> !fire);
   // R3: nothing fires unless armed
   a_r3_fire_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !fire);
endmodule

// File: rtl/acq_prescaler.sv
module acq_prescaler #(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               advance,
   input  logic [PRESC_W-1:0] ratio,
   output logic               keep
);
   localparam int PH_W = PRESC_W;

   generate
      if (PRESC_W < 1) begin : g_bad_width
         $error("acq_prescaler: PRESC_W must be at least 1");
      end
   endgenerate

   logic [PH_W-1:0] phase;
   logic [PH_W:0]   phase_inc;

   assign phase_inc = {1'b0, phase} + 1'b1;
   assign keep      = (phase == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (restart) begin
         phase <= '0;
      end else if (advance) begin
         if (phase_inc >= {1'b0, ratio}) phase <= '0;
         else                            phase <= phase_inc[PH_W-1:0];
      end
   end

   // R8: a restart always lands on a kept position
   a_r8_restart_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> keep);
   // R8: ratio of 0 or 1 with a steady ratio keeps every word
   a_r8_unit_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && ratio <= 1) |=> keep);
endmodule

// File: rtl/acq_seq.sv
module acq_seq
   import acq_pkg::*;
#(
   parameter int WORDS_W = 16,
   parameter int CYC_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               pause_i,
   input  logic               resume_i,
   input  logic               s_valid,
   input  logic               fire,
   input  logic               keep,
   input  logic [WORDS_W-1:0] cfg_words,
   input  logic [CYC_W-1:0]   cfg_cycles,
   output logic               armed,
   output logic               restart,
   output logic               advance,
   output logic               capture,
   output logic               busy,
   output logic               done
);
   acq_state_e         state, resume_to;
   logic [WORDS_W-1:0] wpos;
   logic [CYC_W-1:0]   cyc_cnt;
   logic [WORDS_W:0]   wpos_inc;
   logic [CYC_W:0]     cyc_inc;
   logic               hold;
   logic               last_word;
   logic               cycle_end;
   logic               limit_hit;

   generate
      if (WORDS_W < 1 || CYC_W < 1) begin : g_bad_width
         $error("acq_seq: counter widths must be at least 1");
      end
   endgenerate

   assign hold      = stop_i || pause_i;
   assign armed     = (state == ST_ARMED) && !hold;
   assign restart   = armed && fire;
   assign advance   = (state == ST_CAPT) && s_valid && !hold;
   assign capture   = advance && keep;
   assign wpos_inc  = {1'b0, wpos} + 1'b1;
   assign cyc_inc   = {1'b0, cyc_cnt} + 1'b1;
   assign last_word = (wpos_inc >= {1'b0, cfg_words});
   assign cycle_end = capture && last_word;
   assign limit_hit = (cfg_cycles != '0) && (cyc_inc >= {1'b0, cfg_cycles});
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         resume_to <= ST_ARMED;
         wpos      <= '0;
         cyc_cnt   <= '0;
         done      <= 1'b0;
      end else if (stop_i) begin
         state <= ST_IDLE;
      end else if (pause_i && (state == ST_ARMED || state == ST_CAPT)) begin
         resume_to <= state;
         state     <= ST_PAUSED;
      end else if (resume_i && state == ST_PAUSED) begin
         state <= resume_to;
      end else begin
         unique case (state)
            ST_IDLE: if (start_i) begin
               state   <= ST_ARMED;
               cyc_cnt <= '0;
               done    <= 1'b0;
            end
            ST_ARMED: if (fire) begin
               state <= ST_CAPT;
               wpos  <= '0;
            end
            ST_CAPT: if (capture) begin
               if (last_word) begin
                  wpos <= '0;
                  if (cfg_cycles != '0) cyc_cnt <= cyc_inc[CYC_W-1:0];
                  if (limit_hit) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     state <= ST_ARMED;
                  end
               end else begin
                  wpos <= wpos_inc[WORDS_W-1:0];
               end
            end
            default: ;
         endcase
      end
   end

   // R7: done and busy never both high
   a_r7_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));
   // R11: stop always lands in the stopped state
   a_r11_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (state == ST_IDLE));
   // R6: a running cycle is not cut short by triggers
   a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CAPT && !hold && !cycle_end) |=> (state == ST_CAPT));
   // R9: paused state keeps the in-cycle position
   a_r9_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PAUSED && $past(state) == ST_PAUSED) |-> $stable(wpos));
endmodule

// File: rtl/acq_cycle_ctrl.sv
module acq_cycle_ctrl
   import acq_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int WORDS_W     = 16,
   parameter int CYC_W       = 16,
   parameter int PRESC_W     = 8,
   parameter int CNT_W       = 32,
   parameter bit DIG_EDGE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_valid,
   input  logic [DATA_W-1:0]  s_data,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               pause_i,
   input  logic               resume_i,
   input  logic               flush_i,
   input  logic               sw_trig_i,
   input  logic               hw_dig_i,
   input  logic               hw_ana_i,
   input  logic [1:0]         cfg_mode,
   input  logic [2:0]         cfg_dig_beh,
   input  logic [CYC_W-1:0]   cfg_cycles,
   input  logic [WORDS_W-1:0] cfg_words,
   input  logic [PRESC_W-1:0] cfg_presc,
   output logic               wr_en,
   output logic [DATA_W-1:0]  wr_data,
   output logic [CNT_W-1:0]   word_cnt,
   output logic               busy,
   output logic               done
);
   generate
      if (DATA_W < 1 || CNT_W < 2) begin : g_bad_width
         $error("acq_cycle_ctrl: DATA_W >= 1 and CNT_W >= 2 required");
      end
   endgenerate

   logic armed, fire, restart, advance, capture, keep;

   acq_trig_qual #(.DIG_EDGE_EN(DIG_EDGE_EN)) u_trig (
      .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .dig_beh(cfg_dig_beh),
      .armed(armed), .sw_trig(sw_trig_i), .dig_line(hw_dig_i),
      .ana_pulse(hw_ana_i), .fire(fire)
   );

   acq_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
      .ratio(cfg_presc), .keep(keep)
   );

   acq_seq #(.WORDS_W(WORDS_W), .CYC_W(CYC_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .pause_i(pause_i), .resume_i(resume_i), .s_valid(s_valid),
      .fire(fire), .keep(keep), .cfg_words(cfg_words),
      .cfg_cycles(cfg_cycles), .armed(armed), .restart(restart),
      .advance(advance), .capture(capture), .busy(busy), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en    <= 1'b0;
         wr_data  <= '0;
         word_cnt <= '0;
      end else begin
         wr_en <= capture;
         if (capture) wr_data <= s_data;
         if (flush_i)      word_cnt <= '0;
         else if (capture) word_cnt <= word_cnt + 1'b1;
      end
   end

   // R10: flush clears the counter on the next clock
   a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (word_cnt == '0));
   // R10: without flush the counter moves only with a write
   a_r10_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_i |=> (word_cnt == $past(word_cnt) + (wr_en ? 1 : 0)));
   // R9: nothing is written while paused
   a_r9_no_write_paused: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !armed && !advance && !restart && pause_i) |=> !wr_en);
endmodule

// File: tb/acq_cycle_ctrl_tb.sv
module acq_cycle_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 0, start_i = 0, stop_i = 0, pause_i = 0, resume_i = 0;
   logic        flush_i = 0, sw_trig_i = 0, hw_dig_i = 0, hw_ana_i = 0;
   logic [15:0] s_data = '0;
   logic [1:0]  cfg_mode = '0;
   logic [2:0]  cfg_dig_beh = 3'd1;
   logic [15:0] cfg_cycles = '0, cfg_words = 16'd1;
   logic [7:0]  cfg_presc = '0;
   logic        wr_en, busy, done;
   logic [15:0] wr_data;
   logic [31:0] word_cnt;

   int checks = 0, fails = 0;
   bit finished = 0;
   string tag = "R1";

   // reference state
   int          m_st, m_ret, m_wpos, m_cyc, m_ph;
   bit          m_done, m_prev, m_wr;
   logic [15:0] m_wdata;
   logic [31:0] m_cnt;

   always #4 clk = ~clk;

   acq_cycle_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
      .start_i(start_i), .stop_i(stop_i), .pause_i(pause_i),
      .resume_i(resume_i), .flush_i(flush_i), .sw_trig_i(sw_trig_i),
      .hw_dig_i(hw_dig_i), .hw_ana_i(hw_ana_i), .cfg_mode(cfg_mode),
      .cfg_dig_beh(cfg_dig_beh), .cfg_cycles(cfg_cycles),
      .cfg_words(cfg_words), .cfg_presc(cfg_presc), .wr_en(wr_en),
      .wr_data(wr_data), .word_cnt(word_cnt), .busy(busy), .done(done)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit trig_hit();
      case (cfg_mode)
         2'd0: return 1'b1;
         2'd1: return sw_trig_i;
         2'd2: case (cfg_dig_beh)
                  3'd1: return hw_dig_i;
                  3'd2: return !hw_dig_i;
                  3'd3: return hw_dig_i && !m_prev;
                  3'd4: return !hw_dig_i && m_prev;
                  default: return 1'b0;
               endcase
         default: return hw_ana_i;
      endcase
   endfunction

   task automatic model_reset();
      m_st = 0; m_ret = 1; m_wpos = 0; m_cyc = 0; m_ph = 0;
      m_done = 0; m_prev = 0; m_wr = 0; m_wdata = '0; m_cnt = '0;
   endtask

   // one clock of the reference, from inputs currently driven
   task automatic model_step();
      int n, words;
      bit hold, adv, cap, hit, lastw;
      n     = (cfg_presc == 0) ? 1 : int'(cfg_presc);
      words = int'(cfg_words);
      hold  = stop_i || pause_i;
      hit   = (m_st == 1) && !hold && trig_hit();
      adv   = (m_st == 2) && s_valid && !hold;
      cap   = adv && (m_ph == 0);
      lastw = (m_wpos + 1 >= words);
      m_wr  = cap;
      if (cap) m_wdata = s_data;
      if (flush_i) m_cnt = '0;
      else if (cap) m_cnt = m_cnt + 1;
      if (hit) m_ph = 0;
      else if (adv) m_ph = (m_ph + 1 >= n) ? 0 : m_ph + 1;
      if (stop_i) m_st = 0;
      else if (pause_i && (m_st == 1 || m_st == 2)) begin m_ret = m_st; m_st = 3; end
      else if (resume_i && m_st == 3) m_st = m_ret;
      else if (m_st == 0 && start_i) begin m_st = 1; m_cyc = 0; m_done = 0; end
      else if (m_st == 1 && hit) begin m_st = 2; m_wpos = 0; end
      else if (m_st == 2 && cap) begin
         if (lastw) begin
            m_wpos = 0;
            if (cfg_cycles != 0) begin
               m_cyc = (m_cyc + 1) % 65536;
               if (m_cyc >= int'(cfg_cycles)) begin m_st = 0; m_done = 1; end
               else m_st = 1;
            end else m_st = 1;
         end else m_wpos = m_wpos + 1;
      end
      m_prev = hw_dig_i;
   endtask

   task automatic tick();
      model_step();
      @(negedge clk);
      chk(tag, {31'd0, wr_en}, {31'd0, m_wr}, "wr_en");
      if (m_wr) chk(tag, {16'd0, wr_data}, {16'd0, m_wdata}, "wr_data");
      chk(tag, word_cnt, m_cnt, "word_cnt");
      chk(tag, {31'd0, busy}, {31'd0, (m_st != 0)}, "busy");
      chk(tag, {31'd0, done}, {31'd0, m_done}, "done");
      start_i = 0; stop_i = 0; pause_i = 0; resume_i = 0;
      flush_i = 0; sw_trig_i = 0; hw_ana_i = 0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         s_data = 16'($urandom);
         tick();
      end
   endtask

   task automatic setcfg(int mode, int beh, int cyc, int words, int presc);
      cfg_mode = 2'(mode); cfg_dig_beh = 3'(beh); cfg_cycles = 16'(cyc);
      cfg_words = 16'(words); cfg_presc = 8'(presc);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      finished = 1;
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      tag = "R1";
      chk("R1", {31'd0, busy}, 0, "busy after reset");
      chk("R1", {31'd0, done}, 0, "done after reset");
      chk("R1", {31'd0, wr_en}, 0, "wr_en after reset");
      chk("R1", word_cnt, 0, "word_cnt after reset");

      // R2 free-running, two cycles of four words
      tag = "R2"; setcfg(0, 1, 2, 4, 1); s_valid = 1;
      start_i = 1; tick(); run(2);
      chk("R2", {31'd0, wr_en}, 1, "first write two clocks after arm");
      run(10);
      chk("R7", {31'd0, done}, 1, "done after cycle limit");
      chk("R2", word_cnt, 8, "words over two cycles");

      // R3 software trigger, R6 retrigger ignored
      tag = "R3"; flush_i = 1; tick(); setcfg(1, 1, 1, 3, 0);
      sw_trig_i = 1; tick();
      start_i = 1; tick(); run(3);
      chk("R3", word_cnt, 0, "strobe while stopped ignored");
      sw_trig_i = 1; tick();
      tag = "R6"; sw_trig_i = 1; tick(); run(5);
      chk("R6", word_cnt, 3, "one cycle despite retrigger");
      chk("R6", {31'd0, done}, 1, "run ends after one cycle");

      // R4 digital behaviours
      tag = "R4";
      for (int b = 1; b <= 4; b++) begin
         flush_i = 1; tick(); setcfg(2, b, 1, 2, 0);
         hw_dig_i = (b == 2 || b == 3); tick();
         start_i = 1; tick(); run(4);
         chk("R4", word_cnt, 0, "no trigger at idle level");
         case (b)
            1: begin hw_dig_i = 1; tick(); end
            2: begin hw_dig_i = 0; tick(); end
            3: begin hw_dig_i = 0; tick(); hw_dig_i = 1; tick(); end
            default: begin hw_dig_i = 1; tick(); hw_dig_i = 0; tick(); end
         endcase
         run(6);
         chk("R4", word_cnt, 2, "behaviour qualified trigger");
      end
      for (int b = 0; b < 8; b += 5) begin
         flush_i = 1; tick(); setcfg(2, b, 1, 2, 0);
         start_i = 1; tick();
         for (int i = 0; i < 6; i++) begin hw_dig_i = ~hw_dig_i; tick(); end
         chk("R4", word_cnt, 0, "unknown code never fires");
         stop_i = 1; tick();
      end

      // R5 analog pulse
      tag = "R5"; flush_i = 1; tick(); setcfg(3, 1, 1, 2, 0);
      start_i = 1; tick(); run(3);
      chk("R5", word_cnt, 0, "waiting for analog pulse");
      hw_ana_i = 1; tick(); run(4);
      chk("R5", word_cnt, 2, "analog pulse started cycle");

      // R8 prescaler 3 over two cycles
      tag = "R8"; flush_i = 1; tick(); setcfg(0, 1, 2, 5, 3);
      start_i = 1; tick(); run(40);
      chk("R8", word_cnt, 10, "prescaled words");
      chk("R8", {31'd0, done}, 1, "prescaled run finished");

      // R9 pause mid cycle
      tag = "R9"; flush_i = 1; tick(); setcfg(1, 1, 1, 4, 0);
      start_i = 1; tick(); sw_trig_i = 1; tick(); run(2);
      pause_i = 1; tick(); run(3);
      chk("R9", word_cnt, 2, "frozen while paused");
      chk("R9", {31'd0, busy}, 1, "busy while paused");
      sw_trig_i = 1; tick();
      resume_i = 1; tick(); run(4);
      chk("R9", word_cnt, 4, "cycle completed after resume");
      chk("R9", {31'd0, done}, 1, "done after resumed cycle");

      // R10 flush against write, R7 unlimited
      tag = "R10"; setcfg(0, 1, 0, 3, 0);
      start_i = 1; tick(); run(5);
      flush_i = 1; tick();
      chk("R10", word_cnt, 0, "flush beats write");
      tag = "R7"; run(30);
      chk("R7", {31'd0, busy}, 1, "unlimited cycles keep running");

      // R11 strobe priority
      tag = "R11"; stop_i = 1; pause_i = 1; resume_i = 1; tick();
      chk("R11", {31'd0, busy}, 0, "stop wins");
      chk("R11", {31'd0, done}, 0, "stop does not set done");
      start_i = 1; pause_i = 1; tick();
      chk("R11", {31'd0, busy}, 1, "start acts while stopped");
      pause_i = 1; tick(); start_i = 1; tick(); run(3);
      resume_i = 1; tick(); stop_i = 1; tick();

      // random mix
      tag = "R11";
      for (int i = 0; i < 4000; i++) begin
         if (m_st == 0 && $urandom_range(0, 19) == 0)
            setcfg($urandom_range(0, 3), $urandom_range(0, 5), $urandom_range(0, 3),
                   $urandom_range(0, 6), $urandom_range(0, 3));
         s_valid   = ($urandom_range(0, 9) < 7);
         s_data    = 16'($urandom);
         start_i   = ($urandom_range(0, 29) == 0);
         stop_i    = ($urandom_range(0, 99) == 0);
         pause_i   = ($urandom_range(0, 39) == 0);
         resume_i  = ($urandom_range(0, 9) == 0);
         flush_i   = ($urandom_range(0, 79) == 0);
         sw_trig_i = ($urandom_range(0, 9) == 0);
         hw_ana_i  = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 5) == 0) hw_dig_i = ~hw_dig_i;
         tick();
      end
      finish_run();
   end
endmodule